// File: doc/BRIEF.md
# Streaming S-record Decoder

The block takes an ASCII text stream, one character per cycle in which `in_valid` is high, and decodes it as S-record text while the characters arrive. There is no backpressure: every valid beat is consumed. Each data byte found in a data-carrying record is passed to a downstream writer as a one-cycle write strobe. The strobe comes with the byte and with its offset from the first data address seen in the stream. The writer can drop the bytes into a buffer without knowing the absolute load address.

A record of type 7, 8 or 9 ends the stream. When its checksum is good the block pulses `done` and presents the start address taken from that record. It also presents a byte count equal to the highest written offset plus one. A bad checksum raises one sticky error flag. Framing, type and length problems raise a second sticky flag. After an error or a completed stream the block ignores all input until `restart` is pulsed or `rst` is asserted.

Top module: `srec_stream_decoder`

## Requirements
- R1: Before each record, CR (0x0D), LF (0x0A) and space (0x20) are skipped. Any other character at a record start that is not 'S' (0x53) sets `err_format`.
- R2: The digit after 'S' selects the address field width. Types 1 and 9 use 2 bytes, types 2 and 8 use 3 bytes, types 3 and 7 use 4 bytes, and type 0 has no address. Any other type digit sets `err_format`.
- R3: The length byte counts every byte after it, so data bytes = length − address bytes − 1. A length smaller than address bytes + 1 sets `err_format`.
- R4: The received checksum byte must equal the bitwise inverse of the 8-bit sum of the length, address and data bytes. A mismatch sets `err_checksum` and no `done` follows.
- R5: Each hex character is converted by adding 9 when bit 6 of the character is set and then keeping the low 4 bits, so upper-case and lower-case digits decode alike.
- R6: For each data byte of a type 1, 2 or 3 record, `wr_en` is high for exactly one cycle, in the cycle after the byte's second hex digit is accepted. `wr_data` carries the byte, and `wr_offset` = record address − base + byte index within the record. Type 0 data is checksummed but never written.
- R7: The base is the address of the first record in the stream that is not type 0.
- R8: `done` pulses for one cycle in the cycle after the last checksum digit of a valid type 7, 8 or 9 record. At that point `entry_addr` holds that record's address and `byte_count` holds the highest written offset + 1, or 0 if nothing was written.
- R9: Once an error flag is set it stays set. After an error or after `done`, further input produces no write, no `done` and no new error, until `restart` or `rst`.
- R10: `rst` or `restart` clears `wr_en`, `done`, both error flags, `entry_addr`, `byte_count` and the base, and returns the parser to the record-start state, even in the middle of a record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous clear back to the initial state |
| in_valid | input | 1 | `in_char` holds a character this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle strobe for a decoded data byte |
| wr_offset | output | OFF_W | Offset of the byte from the base address |
| wr_data | output | 8 | Decoded data byte |
| done | output | 1 | One-cycle pulse after a valid termination record |
| entry_addr | output | 32 | Address carried by the termination record |
| byte_count | output | OFF_W+1 | Highest written offset + 1 |
| err_checksum | output | 1 | Sticky checksum-mismatch flag |
| err_format | output | 1 | Sticky framing, type or length error flag |

## Verification
The main decode is driven with three valid streams, each with its own emphasis:
- A plain 2-byte-address data record followed by its termination record, which checks offsets starting at zero.
- A header record, then two 3-byte-address records with a gap between their addresses, which shows that header data is not written and that the base is taken from the first data record.
- Lower-case 4-byte-address records whose addresses go up and then down, which separates "highest offset + 1" from "last offset + 1".

Malformed streams each trip one error source: a stray leading character, an unknown type digit, a too-short length and a corrupted checksum. Directed runs then check that errors and completion stick while further input is ignored, and that a restart in the middle of a record leaves no trace in the next decode.

// File: rtl/srec_pkg.sv
package srec_pkg;

    localparam int ADDR_W = 32;

    localparam logic [7:0] CH_S  = 8'h53;
    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_SP = 8'h20;

    typedef enum logic [2:0] {
        ST_START,
        ST_TYPE,
        ST_LEN,
        ST_ADDR,
        ST_DATA,
        ST_CSUM,
        ST_DONE,
        ST_ERR
    } srec_state_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] addr_bytes;
        logic       final_rec;
        logic       keep;
    } rec_kind_t;

    function automatic logic [3:0] hex_nibble(input logic [7:0] c);
        logic [7:0] t;
        t = c[6] ? (c + 8'd9) : c;
        return t[3:0];
    endfunction

    function automatic rec_kind_t classify(input logic [3:0] d);
        rec_kind_t k;
        k = '0;
        case (d)
            4'd0: k = '{valid: 1'b1, addr_bytes: 3'd0, final_rec: 1'b0, keep: 1'b0};
            4'd1: k = '{valid: 1'b1, addr_bytes: 3'd2, final_rec: 1'b0, keep: 1'b1};
            4'd2: k = '{valid: 1'b1, addr_bytes: 3'd3, final_rec: 1'b0, keep: 1'b1};
            4'd3: k = '{valid: 1'b1, addr_bytes: 3'd4, final_rec: 1'b0, keep: 1'b1};
            4'd7: k = '{valid: 1'b1, addr_bytes: 3'd4, final_rec: 1'b1, keep: 1'b1};
            4'd8: k = '{valid: 1'b1, addr_bytes: 3'd3, final_rec: 1'b1, keep: 1'b1};
            4'd9: k = '{valid: 1'b1, addr_bytes: 3'd2, final_rec: 1'b1, keep: 1'b1};
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/srec_char_decode.sv
module srec_char_decode
    import srec_pkg::*;
(
    input  logic [7:0] ch,
    output logic [3:0] nib,
    output logic       is_blank,
    output logic       is_s
);
    always_comb begin
        nib      = hex_nibble(ch);
        is_blank = (ch == CH_CR) || (ch == CH_LF) || (ch == CH_SP);
        is_s     = (ch == CH_S);
    end
endmodule

// File: rtl/srec_parser.sv
module srec_parser
    import srec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [3:0]        nib,
    input  logic              is_blank,
    input  logic              is_s,
    output logic              addr_stb,
    output logic [ADDR_W-1:0] addr_val,
    output logic              keep_rec,
    output logic              byte_stb,
    output logic [7:0]        byte_val,
    output logic              done,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              err_checksum,
    output logic              err_format
);
    srec_state_e       state;
    rec_kind_t         kind;
    rec_kind_t         kind_now;
    logic              phase;
    logic [3:0]        hi_nib;
    logic [2:0]        left;
    logic [7:0]        data_left;
    logic [7:0]        sum;
    logic [7:0]        need;
    logic [ADDR_W-1:0] addr;
    logic              step;

    always_comb begin
        step     = in_valid && !restart;
        byte_val = {hi_nib, nib};
        addr_val = {addr[ADDR_W-5:0], nib};
        kind_now = classify(nib);
        need     = {5'd0, kind.addr_bytes} + 8'd1;
        keep_rec = kind.keep;
        addr_stb = step && (state == ST_ADDR) && phase && (left == 3'd1);
        byte_stb = step && (state == ST_DATA) && phase && kind.keep;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state        <= ST_START;
            kind         <= '0;
            phase        <= 1'b0;
            hi_nib       <= '0;
            left         <= '0;
            data_left    <= '0;
            sum          <= '0;
            addr         <= '0;
            done         <= 1'b0;
            entry_addr   <= '0;
            err_checksum <= 1'b0;
            err_format   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_valid) begin
                if (state inside {ST_LEN, ST_ADDR, ST_DATA, ST_CSUM}) begin
                    phase <= !phase;
                    if (!phase) hi_nib <= nib;
                end
                case (state)
                    ST_START: begin
                        if (is_s) begin
                            state <= ST_TYPE;
                        end else if (!is_blank) begin
                            err_format <= 1'b1;
                            state      <= ST_ERR;
                        end
                    end
                    ST_TYPE: begin
                        if (!kind_now.valid) begin
                            err_format <= 1'b1;
                            state      <= ST_ERR;
                        end else begin
                            kind  <= kind_now;
                            phase <= 1'b0;
                            state <= ST_LEN;
                        end
                    end
                    ST_LEN: begin
                        if (phase) begin
                            if (byte_val < need) begin
                                err_format <= 1'b1;
                                state      <= ST_ERR;
                            end else begin
                                sum       <= byte_val;
                                data_left <= byte_val - need;
                                left      <= kind.addr_bytes;
                                addr      <= '0;
                                if (kind.addr_bytes != 3'd0) state <= ST_ADDR;
                                else if (byte_val == need)   state <= ST_CSUM;
                                else                         state <= ST_DATA;
                            end
                        end
                    end
                    ST_ADDR: begin
                        addr <= addr_val;
                        if (phase) begin
                            sum  <= sum + byte_val;
                            left <= left - 3'd1;
                            if (left == 3'd1)
                                state <= (data_left == 8'd0) ? ST_CSUM : ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (phase) begin
                            sum       <= sum + byte_val;
                            data_left <= data_left - 8'd1;
                            if (data_left == 8'd1) state <= ST_CSUM;
                        end
                    end
                    ST_CSUM: begin
                        if (phase) begin
                            if (byte_val != ~sum) begin
                                err_checksum <= 1'b1;
                                state        <= ST_ERR;
                            end else if (kind.final_rec) begin
                                done       <= 1'b1;
                                entry_addr <= addr;
                                state      <= ST_DONE;
                            end else begin
                                state <= ST_START;
                            end
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end
endmodule

// File: rtl/srec_offset_track.sv
module srec_offset_track
    import srec_pkg::*;
#(
    parameter int OFF_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              keep_rec,
    input  logic              byte_stb,
    input  logic [7:0]        byte_val,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [7:0]        wr_data,
    output logic [OFF_W:0]    byte_count
);
    localparam int CNT_W = OFF_W + 1;

    logic              first;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] eff_base;
    logic [ADDR_W-1:0] diff;
    logic [OFF_W-1:0]  cur;
    logic [CNT_W-1:0]  next_end;

    always_comb begin
        eff_base = first ? addr_val : base;
        diff     = addr_val - eff_base;
        next_end = {1'b0, cur} + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            first      <= 1'b1;
            base       <= '0;
            cur        <= '0;
            wr_en      <= 1'b0;
            wr_offset  <= '0;
            wr_data    <= '0;
            byte_count <= '0;
        end else begin
            wr_en <= 1'b0;
            if (addr_stb && keep_rec) begin
                if (first) begin
                    base  <= addr_val;
                    first <= 1'b0;
                end
                cur <= diff[OFF_W-1:0];
            end
            if (byte_stb) begin
                wr_en     <= 1'b1;
                wr_offset <= cur;
                wr_data   <= byte_val;
                cur       <= cur + OFF_W'(1);
                if (next_end > byte_count) byte_count <= next_end;
            end
        end
    end
endmodule

// File: rtl/srec_stream_decoder.sv
module srec_stream_decoder
    import srec_pkg::*;
#(
    parameter int OFF_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [OFF_W:0]    byte_count,
    output logic              err_checksum,
    output logic              err_format
);
    logic [3:0]        nib;
    logic              is_blank;
    logic              is_s;
    logic              addr_stb;
    logic [ADDR_W-1:0] addr_val;
    logic              keep_rec;
    logic              byte_stb;
    logic [7:0]        byte_val;

    srec_char_decode u_char (
        .ch       (in_char),
        .nib      (nib),
        .is_blank (is_blank),
        .is_s     (is_s)
    );

    srec_parser u_parse (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .in_valid     (in_valid),
        .nib          (nib),
        .is_blank     (is_blank),
        .is_s         (is_s),
        .addr_stb     (addr_stb),
        .addr_val     (addr_val),
        .keep_rec     (keep_rec),
        .byte_stb     (byte_stb),
        .byte_val     (byte_val),
        .done         (done),
        .entry_addr   (entry_addr),
        .err_checksum (err_checksum),
        .err_format   (err_format)
    );

    srec_offset_track #(.OFF_W(OFF_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .addr_stb   (addr_stb),
        .addr_val   (addr_val),
        .keep_rec   (keep_rec),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .wr_en      (wr_en),
        .wr_offset  (wr_offset),
        .wr_data    (wr_data),
        .byte_count (byte_count)
    );
endmodule

// File: rtl/srec_checker.sv
module srec_checker #(
    parameter int OFF_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic             in_valid,
    input logic [7:0]       in_char,
    input logic             wr_en,
    input logic [OFF_W-1:0] wr_offset,
    input logic [7:0]       wr_data,
    input logic             done,
    input logic [31:0]      entry_addr,
    input logic [OFF_W:0]   byte_count,
    input logic             err_checksum,
    input logic             err_format
);
    assert_no_write_in_error_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !(err_checksum || err_format));

    assert_format_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_format && !restart) |=> err_format);

    assert_checksum_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_checksum && !restart) |=> err_checksum);

    assert_single_error_R4: assert property (@(posedge clk) disable iff (rst)
        !(err_checksum && err_format));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_clean_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err_checksum || err_format || wr_en));

    assert_entry_only_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (done || $stable(entry_addr)));

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!wr_en && !done && !err_checksum && !err_format
                     && byte_count == '0 && entry_addr == '0));
endmodule

bind srec_stream_decoder srec_checker #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_srec_stream_decoder.sv
module tb_srec_stream_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_W = 24;
    localparam int SLEN = 96;

    typedef struct packed {
        logic [8*SLEN-1:0] stream;
        logic [15:0]       tag;
        logic [7:0]        nbytes;
        logic [23:0]       foff;
        logic [7:0]        fdat;
        logic [23:0]       loff;
        logic [7:0]        ldat;
        logic              exp_done;
        logic [31:0]       entry;
        logic [24:0]       count;
        logic              ecs;
        logic              efm;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{"S1051000AABB85\r\nS9031000EC", "R6", 8'd2, 24'h0, 8'hAA, 24'h1, 8'hBB,
          1'b1, 32'h1000, 25'd2, 1'b0, 1'b0},
        '{"S0030000FC\nS2050123451180\nS206012350223330\nS80401234592", "R7", 8'd3,
          24'h0, 8'h11, 24'h0C, 8'h33, 1'b1, 32'h012345, 25'd13, 1'b0, 1'b0},
        '{"S3060000001001E8 S3060000001802df S3060000001203e4 S70500000010EA", "R5", 8'd3,
          24'h0, 8'h01, 24'h2, 8'h03, 1'b1, 32'h10, 25'd9, 1'b0, 1'b0},
        '{"S1051000AABB84", "R4", 8'd2, 24'h0, 8'hAA, 24'h1, 8'hBB,
          1'b0, 32'h0, 25'd0, 1'b1, 1'b0},
        '{"\r\n X", "R1", 8'd0, 24'h0, 8'h0, 24'h0, 8'h0, 1'b0, 32'h0, 25'd0, 1'b0, 1'b1},
        '{"S405", "R2", 8'd0, 24'h0, 8'h0, 24'h0, 8'h0, 1'b0, 32'h0, 25'd0, 1'b0, 1'b1},
        '{"S102", "R3", 8'd0, 24'h0, 8'h0, 24'h0, 8'h0, 1'b0, 32'h0, 25'd0, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             restart = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_char = 8'h0;
    logic             wr_en;
    logic [OFF_W-1:0] wr_offset;
    logic [7:0]       wr_data;
    logic             done;
    logic [31:0]      entry_addr;
    logic [OFF_W:0]   byte_count;
    logic             err_checksum;
    logic             err_format;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int         n_wr = 0;
    int         n_done = 0;
    logic [23:0] log_off [256];
    logic [7:0]  log_dat [256];
    logic [31:0] cap_entry;
    logic [24:0] cap_count;

    srec_stream_decoder #(.OFF_W(OFF_W)) dut (
        .clk (clk), .rst (rst), .restart (restart), .in_valid (in_valid),
        .in_char (in_char), .wr_en (wr_en), .wr_offset (wr_offset),
        .wr_data (wr_data), .done (done), .entry_addr (entry_addr),
        .byte_count (byte_count), .err_checksum (err_checksum),
        .err_format (err_format)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (wr_en) begin
            if (n_wr < 256) begin
                log_off[n_wr] = wr_offset;
                log_dat[n_wr] = wr_data;
            end
            n_wr = n_wr + 1;
        end
        if (done) begin
            n_done    = n_done + 1;
            cap_entry = entry_addr;
            cap_count = byte_count;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
    endtask

    task automatic send_stream(input logic [8*SLEN-1:0] s);
        for (int i = SLEN - 1; i >= 0; i--) begin
            if (s[i*8 +: 8] != 8'h00) send(s[i*8 +: 8]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int w0;
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk({wr_en, done, err_checksum, err_format} == 4'b0, "R10", "flags after reset",
            {60'd0, wr_en, done, err_checksum, err_format}, 64'd0);
        chk(entry_addr == 32'd0 && byte_count == '0, "R10", "entry/count after reset",
            {entry_addr, 7'd0, byte_count}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            w0 = n_wr;
            d0 = n_done;
            send_stream(VECS[v].stream);
            chk(n_wr - w0 == int'(VECS[v].nbytes), string'(VECS[v].tag), "write count",
                64'(n_wr - w0), 64'(VECS[v].nbytes));
            if (VECS[v].nbytes != 0 && n_wr - w0 == int'(VECS[v].nbytes)) begin
                chk(log_off[w0] == VECS[v].foff && log_dat[w0] == VECS[v].fdat,
                    string'(VECS[v].tag), "first write",
                    {32'd0, log_off[w0], log_dat[w0]}, {32'd0, VECS[v].foff, VECS[v].fdat});
                chk(log_off[n_wr-1] == VECS[v].loff && log_dat[n_wr-1] == VECS[v].ldat,
                    string'(VECS[v].tag), "last write",
                    {32'd0, log_off[n_wr-1], log_dat[n_wr-1]},
                    {32'd0, VECS[v].loff, VECS[v].ldat});
            end
            chk(n_done - d0 == int'(VECS[v].exp_done), string'(VECS[v].tag), "done pulses",
                64'(n_done - d0), 64'(VECS[v].exp_done));
            if (VECS[v].exp_done) begin
                chk(cap_entry == VECS[v].entry, "R8", "entry address",
                    64'(cap_entry), 64'(VECS[v].entry));
                chk(cap_count == VECS[v].count, "R8", "byte count",
                    64'(cap_count), 64'(VECS[v].count));
            end
            chk(err_checksum == VECS[v].ecs && err_format == VECS[v].efm,
                string'(VECS[v].tag), "error flags",
                {62'd0, err_checksum, err_format}, {62'd0, VECS[v].ecs, VECS[v].efm});

            if (v == 0) begin
                // R9: input after done is ignored
                w0 = n_wr;
                d0 = n_done;
                send_stream("S1051000AABB85\nS9031000EC");
                chk(n_wr == w0 && n_done == d0 && !err_format && !err_checksum, "R9",
                    "activity after done", 64'(n_wr - w0 + n_done - d0), 64'd0);
            end
            if (v == 3) begin
                // R9: checksum error sticks, valid stream ignored
                w0 = n_wr;
                d0 = n_done;
                send_stream("S1051000AABB85\nS9031000EC");
                chk(n_wr == w0 && n_done == d0, "R9", "activity after error",
                    64'(n_wr - w0 + n_done - d0), 64'd0);
                chk(err_checksum && !err_format, "R9", "sticky checksum flag",
                    {62'd0, err_checksum, err_format}, 64'd2);
            end
            pulse_restart();
            chk({err_checksum, err_format, done} == 3'b0 && byte_count == '0, "R10",
                "state after restart", {61'd0, err_checksum, err_format, done}, 64'd0);
        end

        // R10: restart in the middle of a record leaves no trace
        send_stream("S2060001");
        pulse_restart();
        w0 = n_wr;
        d0 = n_done;
        send_stream("S1051000AABB85\r\nS9031000EC");
        chk(n_wr - w0 == 2 && log_off[w0] == 24'h0 && log_dat[w0] == 8'hAA, "R10",
            "decode after mid-record restart", {32'd0, log_off[w0], log_dat[w0]},
            {32'd0, 24'h0, 8'hAA});
        chk(n_done - d0 == 1 && cap_count == 25'd2, "R10", "count after mid-record restart",
            64'(cap_count), 64'd2);

        summary();
    end
endmodule